// File: doc/BRIEF.md
# Asynchronous Serial Channel with Modem-Line Gating

This block is one full-duplex asynchronous serial channel. It has a transmit holding register that feeds a shift register, and a receiver that oversamples the line. A small register interface lets software write characters, read received characters and status, set the frame format and the baud divider, and enable interrupts. A single interrupt output combines the receive and transmit conditions.

The frame has a start bit, seven or eight data bits sent least significant bit first, an optional extra bit and one or two stop bits. The extra bit is either a parity bit (odd or even) or a ninth bit chosen by software for multiprocessor addressing. Three active-low modem lines are synchronised into the clock domain. When carrier-detect is inactive, the receiver is held idle. When clear-to-send is inactive, only the transmit-ready status is hidden, and a character already written is still shifted out. Request-to-send is driven from a control bit.

Register map (addr): 0 write = transmit character, 0 read = received character (the read consumes it); 1 read = status; 1 write = frame control, 2 read = frame control; 2 write = interrupt control; 3 = baud divider (read and write). Frame control bits: [0] eight data bits, [1] two stop bits, [2] parity enable, [3] odd parity, [4] ninth-bit mode, [5] ninth bit to send, [6] request-to-send on. Interrupt control bits: [0] receive interrupt enable, [1] transmit interrupt enable, [7] clear all error flags. Status bits: [0] receive full, [1] transmit ready, [2] parity error, [3] framing error, [4] overrun, [5] received ninth bit, [6] carrier present, [7] clear-to-send present.

Top module: `async_serial_chan`

## Requirements
- R1: After reset, status reads 0xC2 while the carrier-detect and clear-to-send inputs are low. At the same time txd is 1, irq is 0, rts_n is 1 and the baud divider reads 0.
- R2: A transmitted frame is a 0 start bit, then the data bits LSB first (8 when control bit0=1, otherwise 7), then the extra bit if one is present, then stop bits of 1 (2 when control bit1=1, otherwise 1). Each bit lasts OVS*(divider+1) clocks, and txd is 1 when idle.
- R3: With control bit2=1 and bit4=0, the extra bit is a parity bit over the data bits. It makes the count of ones even when bit3=0 and odd when bit3=1.
- R4: With control bit4=1, the extra bit is control bit5, which takes precedence over parity. On receive, the extra bit is reported in status bit5.
- R5: The receiver samples at OVS times the baud rate and checks the start bit again at mid-bit. A low pulse shorter than half a bit produces no character.
- R6: A received frame sets status bit0 and stores the data. In 7-bit mode, bit7 of the data reads 0. A read of addr 0 clears status bit0.
- R7: With parity enabled and ninth-bit mode off, a received parity bit that does not match sets status bit2.
- R8: A stop bit sampled as 0 sets status bit3.
- R9: A frame that completes while status bit0 is set raises status bit4 and keeps the older character.
- R10: Status bits 2, 3 and 4 stay set until a write to addr 2 with bit7=1.
- R11: While dcd_n is high, status bit6 reads 0 and no frame is received. Reception works again once dcd_n is low.
- R12: While cts_n is high, status bits 1 and 7 read 0. A character written in that state is still transmitted.
- R13: irq is high exactly when (receive enable and (status bit0 or any error flag)) or (transmit enable and status bit1).
- R14: rts_n is the inverse of control bit6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| irq | output | 1 | Interrupt request |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| dcd_n | input | 1 | Carrier detect, active low |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |

## Verification
The bench builds the block with DIV_W=4, OVS=16 and SYNC_STAGES=2. It programs divider values 1 and 3, which give bit times of 32 and 64 clocks. At these rates complete frames with 7 or 8 data bits, parity, the ninth bit and two stop bits fit in a few hundred cycles, and a change of rate shows up directly as wrong sampled bits. Two synchroniser stages on the modem lines and rxd mean the bench must allow for real input latency. The divider width of 4 keeps the bus-to-divider truncation path in use.

// File: rtl/serial_chan_pkg.sv
package serial_chan_pkg;

   localparam int FRAME_MAX = 12;

   typedef struct packed {
      logic rts_on;
      logic mp_bit;
      logic mp_en;
      logic par_odd;
      logic par_en;
      logic stop2;
      logic len8;
   } frame_cfg_t;

   typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_EXTRA, RX_STOP} rx_state_t;

   function automatic logic [3:0] data_len(frame_cfg_t c);
      return c.len8 ? 4'd8 : 4'd7;
   endfunction

   function automatic logic has_extra(frame_cfg_t c);
      return c.mp_en | c.par_en;
   endfunction

   function automatic logic parity_of(frame_cfg_t c, logic [7:0] d);
      logic [7:0] m;
      m = c.len8 ? d : {1'b0, d[6:0]};
      return (^m) ^ c.par_odd;
   endfunction

   function automatic logic extra_bit(frame_cfg_t c, logic [7:0] d);
      return c.mp_en ? c.mp_bit : parity_of(c, d);
   endfunction

   function automatic logic [3:0] frame_len(frame_cfg_t c);
      return 4'd1 + data_len(c) + {3'b000, has_extra(c)} + (c.stop2 ? 4'd2 : 4'd1);
   endfunction

   function automatic logic [FRAME_MAX-1:0] build_frame(frame_cfg_t c, logic [7:0] d);
      logic [FRAME_MAX-1:0] f;
      f    = '1;
      f[0] = 1'b0;
      for (int i = 0; i < 8; i++)
         if (i < int'(data_len(c))) f[i+1] = d[i];
      if (has_extra(c)) f[int'(data_len(c)) + 1] = extra_bit(c, d);
      return f;
   endfunction

endpackage

// File: rtl/serial_chan_sync.sv
module serial_chan_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
            end else begin
               st[0] <= d;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/serial_chan_baud.sv
module serial_chan_baud #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = (cnt >= div);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/serial_chan_tx.sv
module serial_chan_tx
   import serial_chan_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  frame_cfg_t cfg,
   input  logic       wr,
   input  logic [7:0] wdata,
   output logic       hold_empty,
   output logic       busy,
   output logic       txd
);
   localparam int PH_W = $clog2(OVS);

   logic [7:0]           hold;
   logic                 hold_full;
   logic [FRAME_MAX-1:0] sh;
   logic [3:0]           left;
   logic [PH_W-1:0]      ph;
   logic                 unused_rts;

   assign unused_rts = cfg.rts_on;
   assign hold_empty = !hold_full;
   assign txd        = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold      <= '0;
         hold_full <= 1'b0;
         sh        <= '1;
         left      <= '0;
         ph        <= '0;
         busy      <= 1'b0;
      end else begin
         if (wr && !hold_full) begin
            hold      <= wdata;
            hold_full <= 1'b1;
         end
         if (tick) begin
            if (!busy) begin
               if (hold_full) begin
                  sh        <= build_frame(cfg, hold);
                  left      <= frame_len(cfg);
                  ph        <= '0;
                  busy      <= 1'b1;
                  hold_full <= 1'b0;
               end
            end else if (ph == PH_W'(OVS-1)) begin
               ph   <= '0;
               sh   <= {1'b1, sh[FRAME_MAX-1:1]};
               left <= left - 4'd1;
               if (left == 4'd1) busy <= 1'b0;
            end else begin
               ph <= ph + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/serial_chan_rx.sv
module serial_chan_rx
   import serial_chan_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       en,
   input  logic       rxd,
   input  frame_cfg_t cfg,
   output logic       done,
   output logic [7:0] data,
   output logic       ninth,
   output logic       perr,
   output logic       ferr
);
   localparam int PH_W = $clog2(OVS);

   rx_state_t       st;
   logic [7:0]      sh;
   logic [3:0]      cnt;
   logic [PH_W-1:0] ph;
   logic            xbit;
   logic [1:0]      unused_cfg;

   assign unused_cfg = {cfg.rts_on, cfg.mp_bit};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= RX_IDLE;
         sh    <= '0;
         cnt   <= '0;
         ph    <= '0;
         xbit  <= 1'b0;
         done  <= 1'b0;
         data  <= '0;
         ninth <= 1'b0;
         perr  <= 1'b0;
         ferr  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!en) begin
            st <= RX_IDLE;
         end else if (tick) begin
            case (st)
               RX_IDLE: if (!rxd) begin
                  st <= RX_START;
                  ph <= '0;
               end
               RX_START: if (ph == PH_W'(OVS/2-1)) begin
                  if (!rxd) begin
                     st   <= RX_DATA;
                     ph   <= '0;
                     cnt  <= '0;
                     sh   <= '0;
                     xbit <= 1'b0;
                  end else begin
                     st <= RX_IDLE;
                  end
               end else ph <= ph + 1'b1;
               RX_DATA: if (ph == PH_W'(OVS-1)) begin
                  ph           <= '0;
                  sh[cnt[2:0]] <= rxd;
                  cnt          <= cnt + 4'd1;
                  if (cnt == data_len(cfg) - 4'd1)
                     st <= has_extra(cfg) ? RX_EXTRA : RX_STOP;
               end else ph <= ph + 1'b1;
               RX_EXTRA: if (ph == PH_W'(OVS-1)) begin
                  ph   <= '0;
                  xbit <= rxd;
                  st   <= RX_STOP;
               end else ph <= ph + 1'b1;
               RX_STOP: if (ph == PH_W'(OVS-1)) begin
                  ph    <= '0;
                  done  <= 1'b1;
                  data  <= sh;
                  ninth <= cfg.mp_en & xbit;
                  perr  <= cfg.par_en & !cfg.mp_en & (xbit != parity_of(cfg, sh));
                  ferr  <= !rxd;
                  st    <= RX_IDLE;
               end else ph <= ph + 1'b1;
               default: st <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/async_serial_chan.sv
module async_serial_chan
   import serial_chan_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] addr,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       irq,
   input  logic       rxd,
   output logic       txd,
   input  logic       dcd_n,
   input  logic       cts_n,
   output logic       rts_n
);
   generate
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
         $error("DIV_W must lie in 1..8");
      end
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 4");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   frame_cfg_t       cfg;
   logic             rx_ie, tx_ie;
   logic [DIV_W-1:0] div;
   logic             rx_full, rx_ninth, perr_f, ferr_f, ovr_f;
   logic [7:0]       rx_data;
   logic [2:0]       s_q;
   logic             rxd_s, dcd_off, cts_off;
   logic             tick, hold_empty, tx_busy, tdre;
   logic             rx_done, rx_ninth_n, rx_perr, rx_ferr;
   logic [7:0]       rx_byte;
   logic             rd_data;
   logic [7:0]       status;

   serial_chan_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cts_n, dcd_n, rxd}), .q(s_q));

   assign rxd_s   = s_q[0];
   assign dcd_off = s_q[1];
   assign cts_off = s_q[2];

   serial_chan_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .div(div), .tick(tick));

   serial_chan_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg),
      .wr(wr_en && addr == 2'd0), .wdata(wdata),
      .hold_empty(hold_empty), .busy(tx_busy), .txd(txd));

   serial_chan_rx #(.OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(!dcd_off), .rxd(rxd_s), .cfg(cfg),
      .done(rx_done), .data(rx_byte), .ninth(rx_ninth_n), .perr(rx_perr), .ferr(rx_ferr));

   assign rd_data = rd_en && addr == 2'd0;
   assign tdre    = hold_empty & !cts_off;
   assign status  = {!cts_off, !dcd_off, rx_ninth, ovr_f, ferr_f, perr_f, tdre, rx_full};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg      <= '0;
         rx_ie    <= 1'b0;
         tx_ie    <= 1'b0;
         div      <= '0;
         rx_full  <= 1'b0;
         rx_data  <= '0;
         rx_ninth <= 1'b0;
         perr_f   <= 1'b0;
         ferr_f   <= 1'b0;
         ovr_f    <= 1'b0;
      end else begin
         if (wr_en) begin
            case (addr)
               2'd1: cfg <= frame_cfg_t'(wdata[6:0]);
               2'd2: begin
                  rx_ie <= wdata[0];
                  tx_ie <= wdata[1];
                  if (wdata[7]) begin
                     perr_f <= 1'b0;
                     ferr_f <= 1'b0;
                     ovr_f  <= 1'b0;
                  end
               end
               2'd3: div <= wdata[DIV_W-1:0];
               default: ;
            endcase
         end
         if (rd_data) rx_full <= 1'b0;
         if (rx_done) begin
            if (rx_full && !rd_data) begin
               ovr_f <= 1'b1;
            end else begin
               rx_data  <= rx_byte;
               rx_ninth <= rx_ninth_n;
               rx_full  <= 1'b1;
            end
            if (rx_perr) perr_f <= 1'b1;
            if (rx_ferr) ferr_f <= 1'b1;
         end
      end
   end

   always_comb begin
      case (addr)
         2'd0:    rdata = rx_data;
         2'd1:    rdata = status;
         2'd2:    rdata = {1'b0, cfg};
         default: rdata = 8'(div);
      endcase
   end

   assign irq   = (rx_ie & (rx_full | perr_f | ferr_f | ovr_f)) | (tx_ie & tdre);
   assign rts_n = !cfg.rts_on;

endmodule

// File: rtl/serial_chan_checker.sv
module serial_chan_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] addr,
   input logic       wr_en,
   input logic [7:0] wdata,
   input logic       rts_n,
   input logic       irq,
   input logic       rx_ie,
   input logic       rx_full,
   input logic       ovr_f,
   input logic [7:0] rx_data,
   input logic       perr_f,
   input logic       dcd_off,
   input logic       tx_busy,
   input logic       txd
);
   assert_txd_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);

   assert_overrun_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_f) |-> $stable(rx_data));

   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(perr_f) |-> $past(wr_en && addr == 2'd2 && wdata[7]));

   assert_no_rx_without_carrier_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (dcd_off && $past(dcd_off)) |=> !$rose(rx_full));

   assert_irq_rx_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ie && rx_full) |-> irq);

   assert_rts_follows_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd1) |=> (rts_n == !$past(wdata[6])));
endmodule

bind async_serial_chan serial_chan_checker u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
   .rts_n(rts_n), .irq(irq), .rx_ie(rx_ie), .rx_full(rx_full), .ovr_f(ovr_f),
   .rx_data(rx_data), .perr_f(perr_f), .dcd_off(dcd_off), .tx_busy(tx_busy), .txd(txd));

// File: tb/async_serial_chan_tb.sv
module async_serial_chan_tb;
   localparam int DIV_W = 4;
   localparam int OVS   = 16;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0, rdata;
   logic       irq, txd, rts_n;
   logic       rxd = 1'b1, dcd_n = 1'b0, cts_n = 1'b0;

   int checks = 0, errors = 0, cyc = 0;
   int per = OVS;

   async_serial_chan #(.DIV_W(DIV_W), .OVS(OVS), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .irq(irq), .rxd(rxd), .txd(txd),
      .dcd_n(dcd_n), .cts_n(cts_n), .rts_n(rts_n));

   always #2 clk = ~clk;
   always @(posedge clk) cyc++;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic set_baud(input int b);
      wr(2'd3, 8'(b));
      per = OVS * (b + 1);
   endtask

   // frame from requirement R2/R3/R4: cfg bits [0]len8 [1]stop2 [2]par [3]odd [4]mp [5]mpbit
   task automatic mk_frame(input logic [7:0] c, input logic [7:0] d,
                           output logic [11:0] f, output int n);
      int nd, idx;
      logic p;
      nd = c[0] ? 8 : 7;
      f = '1; f[0] = 1'b0; idx = 1; p = c[3];
      for (int i = 0; i < nd; i++) begin f[idx] = d[i]; p ^= d[i]; idx++; end
      if (c[4]) begin f[idx] = c[5]; idx++; end
      else if (c[2]) begin f[idx] = p; idx++; end
      n = idx + (c[1] ? 2 : 1);
   endtask

   task automatic send_rx(input logic [11:0] f, input int n, input int last_len);
      for (int i = 0; i < n; i++) begin
         rxd = f[i];
         repeat (i == n - 1 ? last_len : per) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic capture_tx(input int n, output logic [11:0] f, output int t0);
      int w = 0;
      while (txd !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
      t0 = cyc;
      repeat (per / 2) @(negedge clk);
      f = '1;
      for (int i = 0; i < n; i++) begin
         f[i] = txd;
         if (i < n - 1) repeat (per) @(negedge clk);
      end
   endtask

   task automatic tx_one(input string req, input logic [7:0] c, input logic [7:0] d,
                         output logic [11:0] got);
      logic [11:0] exp_f;
      int n, t0;
      mk_frame(c, d, exp_f, n);
      wr(2'd0, d);
      capture_tx(n, got, t0);
      check(req, 32'(got), 32'(exp_f));
      repeat (per) @(negedge clk);
   endtask

   task automatic rx_one(input logic [7:0] c, input logic [7:0] d);
      logic [11:0] f;
      int n;
      mk_frame(c, d, f, n);
      send_rx(f, n, per);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(2'd1, v); check("R1 status", 32'(v), 32'hC2);
      check("R1 txd", 32'(txd), 1);
      check("R1 irq", 32'(irq), 0);
      check("R1 rts_n", 32'(rts_n), 1);
      rd(2'd3, v); check("R1 divider", 32'(v), 0);
   endtask

   task automatic t_tx_formats();
      logic [11:0] e0, e1, g0, g1, g;
      int n, t0, t1;
      wr(2'd1, 8'h03);                       // 8 data, 2 stop
      mk_frame(8'h03, 8'hA5, e0, n);
      mk_frame(8'h03, 8'h3C, e1, n);
      wr(2'd0, 8'hA5);
      repeat (6) @(negedge clk);
      wr(2'd0, 8'h3C);
      capture_tx(n, g0, t0);
      capture_tx(n, g1, t1);
      check("R2 8N2 first", 32'(g0), 32'(e0));
      check("R2 8N2 second", 32'(g1), 32'(e1));
      check("R2 two stop spacing", 32'((t1 - t0) >= 11 * per - 4 && (t1 - t0) <= 11 * per + 4), 1);
      repeat (2 * per) @(negedge clk);
      wr(2'd1, 8'h04);                       // 7 data, even parity
      tx_one("R3 7E1 frame", 8'h04, 8'h55, g);
      check("R3 even parity bit", 32'(g[8]), 0);
      wr(2'd1, 8'h0D);                       // 8 data, odd parity
      tx_one("R3 8O1 frame", 8'h0D, 8'h81, g);
      check("R3 odd parity bit", 32'(g[9]), 1);
   endtask

   task automatic t_mp_tx();
      logic [11:0] g;
      wr(2'd1, 8'h35);                       // mp on, mp bit 1, parity also on
      tx_one("R4 ninth frame", 8'h35, 8'h00, g);
      check("R4 ninth bit wins over parity", 32'(g[9]), 1);
   endtask

   task automatic t_rx_basic();
      logic [7:0] v;
      wr(2'd1, 8'h01);
      rx_one(8'h01, 8'h96);
      rd(2'd1, v); check("R6 rx full set", 32'(v[0]), 1);
      rd(2'd0, v); check("R6 rx data 8N1", 32'(v), 32'h96);
      rd(2'd1, v); check("R6 rx full cleared by read", 32'(v[0]), 0);
      wr(2'd1, 8'h00);
      rx_one(8'h00, 8'hFF);
      rd(2'd0, v); check("R6 rx data 7N1 top bit zero", 32'(v), 32'h7F);
   endtask

   task automatic t_glitch();
      logic [7:0] v;
      wr(2'd1, 8'h01);
      rxd = 1'b0; repeat (6) @(negedge clk); rxd = 1'b1;
      repeat (3 * per) @(negedge clk);
      rd(2'd1, v); check("R5 short low pulse ignored", 32'(v), 32'hC2);
   endtask

   task automatic t_parity();
      logic [7:0] v;
      logic [11:0] f;
      int n;
      wr(2'd1, 8'h05);
      rx_one(8'h05, 8'h31);
      rd(2'd1, v); check("R7 good parity no flag", 32'(v[2]), 0);
      rd(2'd0, v);
      mk_frame(8'h05, 8'h31, f, n);
      f[9] = ~f[9];
      send_rx(f, n, per);
      rd(2'd1, v); check("R7 parity error flag", 32'(v[2]), 1);
      rd(2'd0, v); check("R7 data kept", 32'(v), 32'h31);
      rd(2'd1, v); check("R10 parity flag sticky after read", 32'(v[2]), 1);
      wr(2'd2, 8'h80);
      rd(2'd1, v); check("R10 flags cleared by write", 32'(v[4:2]), 0);
   endtask

   task automatic t_framing();
      logic [7:0] v;
      logic [11:0] f;
      int n;
      wr(2'd1, 8'h01);
      mk_frame(8'h01, 8'h42, f, n);
      f[9] = 1'b0;
      send_rx(f, n, per / 2 + 8);
      rd(2'd1, v); check("R8 framing flag", 32'(v[3]), 1);
      rd(2'd0, v); check("R8 data stored", 32'(v), 32'h42);
      wr(2'd2, 8'h80);
      rd(2'd1, v); check("R10 framing cleared", 32'(v[3]), 0);
   endtask

   task automatic t_overrun();
      logic [7:0] v;
      rx_one(8'h01, 8'h11);
      rx_one(8'h01, 8'h22);
      rd(2'd1, v); check("R9 overrun flag", 32'(v[4]), 1);
      rd(2'd0, v); check("R9 older byte kept", 32'(v), 32'h11);
      rd(2'd1, v); check("R10 overrun sticky", 32'(v[4]), 1);
      wr(2'd2, 8'h80);
   endtask

   task automatic t_mp_rx();
      logic [7:0] v;
      wr(2'd1, 8'h11);
      rx_one(8'h31, 8'h5C);                  // sender places ninth bit = 1
      rd(2'd1, v); check("R4 received ninth bit", 32'(v[5]), 1);
      rd(2'd0, v); check("R4 data with ninth bit", 32'(v), 32'h5C);
   endtask

   task automatic t_dcd();
      logic [7:0] v;
      wr(2'd1, 8'h01);
      dcd_n = 1'b1; repeat (4) @(negedge clk);
      rd(2'd1, v); check("R11 carrier status off", 32'(v[6]), 0);
      rx_one(8'h01, 8'h77);
      rd(2'd1, v); check("R11 no frame without carrier", 32'(v[0]), 0);
      dcd_n = 1'b0; repeat (4) @(negedge clk);
      rx_one(8'h01, 8'h78);
      rd(2'd0, v); check("R11 reception after carrier back", 32'(v), 32'h78);
   endtask

   task automatic t_cts();
      logic [7:0] v;
      logic [11:0] g;
      cts_n = 1'b1; repeat (4) @(negedge clk);
      rd(2'd1, v); check("R12 ready and cts hidden", 32'({v[7], v[1]}), 0);
      tx_one("R12 char sent without cts", 8'h01, 8'h5A, g);
      cts_n = 1'b0; repeat (4) @(negedge clk);
      rd(2'd1, v); check("R12 ready back", 32'(v[1]), 1);
   endtask

   task automatic t_irq();
      logic [7:0] v;
      wr(2'd2, 8'h01);
      check("R13 irq low no event", 32'(irq), 0);
      rx_one(8'h01, 8'h10);
      check("R13 irq on rx full", 32'(irq), 1);
      rd(2'd0, v);
      @(negedge clk); check("R13 irq low after read", 32'(irq), 0);
      wr(2'd2, 8'h02);
      @(negedge clk); check("R13 irq on tx ready", 32'(irq), 1);
      cts_n = 1'b1; repeat (4) @(negedge clk);
      check("R13 irq off when cts lost", 32'(irq), 0);
      cts_n = 1'b0;
      wr(2'd2, 8'h00);
   endtask

   task automatic t_rts();
      logic [7:0] v;
      wr(2'd1, 8'h41);
      @(negedge clk); check("R14 rts asserted", 32'(rts_n), 0);
      rd(2'd2, v); check("R14 control readback", 32'(v), 32'h41);
      wr(2'd1, 8'h01);
      @(negedge clk); check("R14 rts released", 32'(rts_n), 1);
   endtask

   task automatic t_slow_rate();
      logic [7:0] v;
      logic [11:0] g;
      set_baud(3);
      wr(2'd1, 8'h01);
      tx_one("R2 slower rate frame", 8'h01, 8'hC3, g);
      rx_one(8'h01, 8'h3A);
      rd(2'd0, v); check("R2 slower rate receive", 32'(v), 32'h3A);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      set_baud(1);
      t_tx_formats();
      t_mp_tx();
      t_rx_basic();
      t_glitch();
      t_parity();
      t_framing();
      t_overrun();
      t_mp_rx();
      t_dcd();
      t_cts();
      t_irq();
      t_rts();
      t_slow_rate();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule